// File: doc/BRIEF.md
# Queue Interrupt Source Controller

This block turns per-queue fill-level flags into one interrupt line for a bank of hardware queues. Each queue has a three-bit code that picks which of eight conditions it watches: one of four fill levels (empty, nearly empty, nearly full, full) or the inverse of one of them. A rising edge of the picked condition latches a pending bit for that queue. Software reads the pending bits, acknowledges them by writing ones, and chooses which queues may reach the interrupt line through an enable mask.

The block sits beside the queue status logic, which supplies the four flag vectors. Software talks to it over a plain 32-bit register port: a write takes effect at the clock edge where it is presented, and a read returns its data on the cycle after the request. The block has no streaming data path, so every pin is a plain control or status pin with no back-pressure.

Register words (default configuration): words 0 to 3 hold source codes for queues 0-7, 8-15, 16-23 and 24-31; word 4 is the pending-status register; word 5 is the enable mask; words 6 and 7 are unmapped.

Top module: `qirq_ctrl`

## Requirements
- R1: After reset every source code, every pending bit and every enable bit is zero, and `irq` is low.
- R2: The source code of queue q sits in word q/8 at bits (q mod 8)*4+2 down to (q mod 8)*4; bit (q mod 8)*4+3 of each slot ignores writes and reads as zero.
- R3: Source code 0 selects empty, 1 nearly empty, 2 nearly full, 3 full, 4 not empty, 5 not nearly empty, 6 not nearly full, 7 not full; flags outside the selected one cannot set the queue's pending bit.
- R4: A pending bit is set only by a low-to-high change of the selected condition; a condition held high does not set it again after it is cleared, and a condition already high when reset ends does not set it.
- R5: Writing a 1 to bit q of the status word (word 4) clears pending bit q; writing 0 leaves it unchanged.
- R6: When a rising edge and a clear of the same pending bit occur in the same cycle, the bit ends up set.
- R7: Writing the enable word (word 5) so that bit q goes from 1 to 0 also clears pending bit q; a bit going from 0 to 1 or staying 1 leaves the pending bit unchanged.
- R8: `irq` equals the OR over all queues of pending AND enable, delayed by one register; a pending bit with its enable at 0 never raises `irq`.
- R9: Read data appears on `bus_rdata` one cycle after `bus_rd`; unmapped words read as zero and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Register word index |
| bus_wr | input | 1 | Write strobe, acts at this clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| q_empty | input | NUM_Q (32) | Per-queue empty flag |
| q_near_empty | input | NUM_Q (32) | Per-queue nearly-empty flag |
| q_near_full | input | NUM_Q (32) | Per-queue nearly-full flag |
| q_full | input | NUM_Q (32) | Per-queue full flag |
| irq | output | 1 | Registered interrupt request |

## Verification
Every cycle, the checker confirms that `irq` tracks the previous cycle's masked pending vector, that no pending bit rises without a detected edge, that none falls without a clear request, that an edge beats a simultaneous clear, and that reserved slot bits read back as zero. Only the bench scenarios can show that each of the eight source codes picks the correct flag for every one of the 32 queues, that a held condition does not retrigger, that a disable write clears the pending bit while an enable write does not, and that unmapped words stay zero.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

  localparam int DATA_W        = 32;
  localparam int CODE_W        = 3;
  localparam int SLOT_W        = 4;
  localparam int SLOTS_PER_REG = DATA_W / SLOT_W;

  // Condition selector; bit 2 inverts the level picked by bits 1:0.
  typedef enum logic [CODE_W-1:0] {
    SRC_EMPTY      = 3'd0,
    SRC_NEAR_EMPTY = 3'd1,
    SRC_NEAR_FULL  = 3'd2,
    SRC_FULL       = 3'd3,
    SRC_NOT_EMPTY  = 3'd4,
    SRC_NOT_NEMPTY = 3'd5,
    SRC_NOT_NFULL  = 3'd6,
    SRC_NOT_FULL   = 3'd7
  } src_code_e;

  // Reserved (top) bit of every 4-bit slot.
  localparam logic [DATA_W-1:0] SLOT_RSV_MASK = {SLOTS_PER_REG{4'b1000}};

endpackage

// File: rtl/qirq_cond_select.sv
module qirq_cond_select
  import qirq_pkg::*;
#(
  parameter int NUM_Q = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_Q-1:0][CODE_W-1:0]   code,
  input  logic [NUM_Q-1:0]               q_empty,
  input  logic [NUM_Q-1:0]               q_near_empty,
  input  logic [NUM_Q-1:0]               q_near_full,
  input  logic [NUM_Q-1:0]               q_full,
  output logic [NUM_Q-1:0]               rise
);

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      logic base_lvl;
      logic sel_lvl;
      logic prev_lvl;

      always_comb begin
        case (src_code_e'({1'b0, code[q][1:0]}))
          SRC_EMPTY:      base_lvl = q_empty[q];
          SRC_NEAR_EMPTY: base_lvl = q_near_empty[q];
          SRC_NEAR_FULL:  base_lvl = q_near_full[q];
          default:        base_lvl = q_full[q];
        endcase
      end

      assign sel_lvl = base_lvl ^ code[q][2];

      // Seeded high so a level already asserted at reset exit is no edge.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl <= 1'b1;
        else        prev_lvl <= sel_lvl;
      end

      assign rise[q] = sel_lvl & ~prev_lvl;
    end
  endgenerate

endmodule

// File: rtl/qirq_regs.sv
module qirq_regs
  import qirq_pkg::*;
#(
  parameter int NUM_Q  = 32,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic                          bus_rd,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_Q-1:0]              status,
  output logic [NUM_Q-1:0][CODE_W-1:0]  code,
  output logic [NUM_Q-1:0]              enable,
  output logic [NUM_Q-1:0]              clr
);

  localparam int NSEL       = NUM_Q / SLOTS_PER_REG;
  localparam int STATUS_IDX = NSEL;
  localparam int ENABLE_IDX = NSEL + 1;

  logic [NUM_Q-1:0][CODE_W-1:0] code_q;
  logic [NUM_Q-1:0]             enable_q;
  logic [DATA_W-1:0]            rd_mux;
  logic                         hit_status;
  logic                         hit_enable;

  assign hit_status = (bus_addr == ADDR_W'(STATUS_IDX));
  assign hit_enable = (bus_addr == ADDR_W'(ENABLE_IDX));

  // One write port per source-select word.
  generate
    for (genvar r = 0; r < NSEL; r++) begin : g_sel
      for (genvar s = 0; s < SLOTS_PER_REG; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            code_q[r*SLOTS_PER_REG+s] <= '0;
          end else if (bus_wr && bus_addr == ADDR_W'(r)) begin
            code_q[r*SLOTS_PER_REG+s] <= bus_wdata[s*SLOT_W +: CODE_W];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   enable_q <= '0;
    else if (bus_wr && hit_enable) enable_q <= bus_wdata[NUM_Q-1:0];
  end

  // Clear request: explicit write-one-to-clear, or an enable bit dropping.
  always_comb begin
    clr = '0;
    if (bus_wr && hit_status) clr = bus_wdata[NUM_Q-1:0];
    if (bus_wr && hit_enable) clr = enable_q & ~bus_wdata[NUM_Q-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < NSEL; r++) begin
      if (bus_addr == ADDR_W'(r)) begin
        for (int s = 0; s < SLOTS_PER_REG; s++) begin
          rd_mux[s*SLOT_W +: CODE_W] = code_q[r*SLOTS_PER_REG+s];
        end
      end
    end
    if (hit_status) rd_mux[NUM_Q-1:0] = status;
    if (hit_enable) rd_mux[NUM_Q-1:0] = enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign code   = code_q;
  assign enable = enable_q;

endmodule

// File: rtl/qirq_status.sv
module qirq_status #(
  parameter int NUM_Q = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] rise,
  input  logic [NUM_Q-1:0] clr,
  input  logic [NUM_Q-1:0] enable,
  output logic [NUM_Q-1:0] status,
  output logic             irq
);

  logic [NUM_Q-1:0] status_q;
  logic             irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      // Set term applied after the clear term: a same-cycle edge survives.
      status_q <= (status_q & ~clr) | rise;
      irq_q    <= |(status_q & enable);
    end
  end

  assign status = status_q;
  assign irq    = irq_q;

endmodule

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
  import qirq_pkg::*;
#(
  parameter int NUM_Q  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_Q-1:0]  q_empty,
  input  logic [NUM_Q-1:0]  q_near_empty,
  input  logic [NUM_Q-1:0]  q_near_full,
  input  logic [NUM_Q-1:0]  q_full,
  output logic              irq
);

  logic [NUM_Q-1:0][CODE_W-1:0] code_vec;
  logic [NUM_Q-1:0]             rise_vec;
  logic [NUM_Q-1:0]             clr_vec;
  logic [NUM_Q-1:0]             enable_vec;
  logic [NUM_Q-1:0]             status_vec;

  qirq_cond_select #(.NUM_Q(NUM_Q)) u_cond (
    .clk          (clk),
    .rst_n        (rst_n),
    .code         (code_vec),
    .q_empty      (q_empty),
    .q_near_empty (q_near_empty),
    .q_near_full  (q_near_full),
    .q_full       (q_full),
    .rise         (rise_vec)
  );

  qirq_regs #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .status    (status_vec),
    .code      (code_vec),
    .enable    (enable_vec),
    .clr       (clr_vec)
  );

  qirq_status #(.NUM_Q(NUM_Q)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (rise_vec),
    .clr    (clr_vec),
    .enable (enable_vec),
    .status (status_vec),
    .irq    (irq)
  );

endmodule

// File: rtl/qirq_ctrl_chk.sv
module qirq_ctrl_chk
  import qirq_pkg::*;
#(
  parameter int NUM_Q  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NUM_Q-1:0]  rise,
  input logic [NUM_Q-1:0]  clr,
  input logic [NUM_Q-1:0]  status,
  input logic [NUM_Q-1:0]  enable,
  input logic              irq
);

  localparam int NSEL = NUM_Q / SLOTS_PER_REG;

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status & enable))));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((status & $past(rise)) == $past(rise)));

  // R4
  set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(rise)) == {NUM_Q{1'b0}}));

  // R5
  clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status & $past(status) & ~$past(clr)) == {NUM_Q{1'b0}}));

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr < ADDR_W'(NSEL))) |=> ((bus_rdata & SLOT_RSV_MASK) == 32'd0));

endmodule

bind qirq_ctrl qirq_ctrl_chk #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .rise      (rise_vec),
  .clr       (clr_vec),
  .status    (status_vec),
  .enable    (enable_vec),
  .irq       (irq)
);

// File: tb/qirq_ctrl_tb.sv
module qirq_ctrl_tb;

  localparam int NQ = 32;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_STATUS = 3'd4;
  localparam logic [AW-1:0] A_ENABLE = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NQ-1:0] f_e = '0, f_ne = '0, f_nf = '0, f_f = '0;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  qirq_ctrl #(.NUM_Q(NQ), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .q_empty(f_e), .q_near_empty(f_ne), .q_near_full(f_nf), .q_full(f_f),
    .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_flag(int q, int idx, logic v);
    case (idx)
      0: f_e[q]  = v;
      1: f_ne[q] = v;
      2: f_nf[q] = v;
      default: f_f[q] = v;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    // R4: empty flag of queue 3 already high when reset ends
    f_e[3] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      rd(AW'(a), d);
      check("R1 reg", d, 32'd0);
    end
    rd(A_STATUS, d);
    check("R4 high-at-reset no set", d, 32'd0);
    f_e[3] = 1'b0;
    @(negedge clk);

    // R2/R3 sweep: every queue, every code
    for (int q = 0; q < NQ; q++) begin
      for (int c = 0; c < 8; c++) begin
        logic bv;
        int sh;
        bv = (c >= 4);
        sh = (q % 8) * 4;
        for (int k = 0; k < 4; k++) set_flag(q, k, bv);
        @(negedge clk);
        wr(AW'(q / 8), (32'(c) << sh) | 32'h8888_8888);
        rd(AW'(q / 8), d);
        check("R2 slot readback", d, 32'(c) << sh);
        wr(A_STATUS, 32'hFFFF_FFFF);
        set_flag(q, (c + 1) % 4, ~bv);
        rd(A_STATUS, d);
        check("R3 other flag ignored", d, 32'd0);
        set_flag(q, c % 4, ~bv);
        rd(A_STATUS, d);
        check("R3 selected flag sets", d, 32'd1 << q);
        check("R8 disabled no irq", {31'd0, irq}, 32'd0);
        for (int k = 0; k < 4; k++) set_flag(q, k, 1'b0);
        wr(AW'(q / 8), 32'd0);
        wr(A_STATUS, 32'hFFFF_FFFF);
      end
    end

    // R6: edge and clear in the same cycle
    @(negedge clk);
    f_e[10] = 1'b1;
    bus_wr = 1'b1; bus_addr = A_STATUS; bus_wdata = 32'd1 << 10;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(A_STATUS, d);
    check("R6 set wins", d, 32'd1 << 10);

    // R5: zero write no effect, one write clears
    wr(A_STATUS, 32'd0);
    rd(A_STATUS, d);
    check("R5 write0 keeps", d, 32'd1 << 10);
    wr(A_STATUS, 32'd1 << 10);
    rd(A_STATUS, d);
    check("R5 write1 clears", d, 32'd0);

    // R4: held level does not retrigger
    repeat (4) @(negedge clk);
    rd(A_STATUS, d);
    check("R4 held level", d, 32'd0);

    // R8: irq one register after status
    f_e[10] = 1'b0;
    wr(A_ENABLE, 32'd1 << 10);
    @(negedge clk);
    f_e[10] = 1'b1;
    @(negedge clk);
    check("R8 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R8 irq high", {31'd0, irq}, 32'd1);

    // R7: enabling another bit keeps status; disabling clears it
    wr(A_ENABLE, (32'd1 << 10) | (32'd1 << 11));
    rd(A_STATUS, d);
    check("R7 enable keeps status", d, 32'd1 << 10);
    wr(A_ENABLE, 32'd0);
    rd(A_STATUS, d);
    check("R7 disable clears", d, 32'd0);
    rd(A_ENABLE, d);
    check("R7 enable readback", d, 32'd0);
    check("R8 irq low after disable", {31'd0, irq}, 32'd0);

    // R9: unmapped words
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, d);
    check("R9 unmapped 6", d, 32'd0);
    rd(3'd7, d);
    check("R9 unmapped 7", d, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(AW'(a), d);
      check("R9 no side effect", d, 32'd0);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule